// File: doc/BRIEF.md
# Sequential Round-Subkey Generator

This block holds a 128-bit secret key and hands a compact 64-bit Feistel cipher datapath one 16-bit round subkey at a time. The datapath names a round and a subkey slot: one of four output-mixing words (KO), three inner-function words (KI) or two FL-layer halves (KL). The block answers with the matching 16-bit word. There is no table of derived keys. The secret key is viewed as eight 16-bit words, K1 on the left. A derived word K'j is rebuilt on demand by passing Kj through the cipher's 16-bit nonlinear FI function, keyed with the next word in circular order. The result goes into the single 16-bit output register.

A slot that comes straight from the secret key is answered one cycle after the request. A derived slot takes one more cycle, because the FI result is registered. The answer stays on the output until the next accepted request or the next key load. Loading a key drops any pending derived-word computation.

Top module: `subkey_gen`

## Requirements
- R1: The secret key splits into words K1..K8, with Kn = key[143-16n : 128-16n] (K1 is bits 127:112). Selector codes 0, 1, 2 and 3 (KO1..KO4) return K(r), K(r+2), K(r+7) and K(r+4) for round r, 1..8. `ready` rises in the first cycle after the accepting edge, with the word on `subkey`.
- R2: Selector codes 4, 5 and 6 (KI1..KI3) return K'(r+5), K'(r+1) and K'(r+3). Here K'j = FI(Kj, K(j mod 8 + 1)). `ready` is low in the first cycle after acceptance and high, with the word, in the second.
- R3: FI(x, k) works on halves a = x[15:7] (9 bits) and b = x[6:0] (7 bits):
  - a = S9(a) ^ zext(b); b = S7(b) ^ a[6:0]
  - b ^= k[15:9]; a ^= k[8:0]
  - a = S9(a) ^ zext(b); b = S7(b) ^ a[6:0]
  - result = {b, a}
  S7(v) is v cubed in GF(2^7) modulo x^7+x+1. S9(v) is v cubed in GF(2^9) modulo x^9+x^4+1.
- R4: Selector codes 7 (KL left) and 8 (KL right) serve FL layers r = 1..10.
  - Odd r: left = K((r+1)/2), right = K'((r+1)/2+6).
  - Even r: left = K'(r/2+2), right = K(r/2+4).
  Words from K arrive on the R1 timing; words from K' arrive on the R2 timing.
- R5: Any word index above 8 wraps to index-8; for example, round 8 KO3 returns K7.
- R6: While no request is accepted and no key is loaded, `ready` and `subkey` hold their values.
- R7: When `key_load` is high at an edge, the key is replaced, `ready` goes low, a pending derived-word computation is abandoned, and a request in the same cycle is dropped.
- R8: A request with a selector code above 8 is ignored: `ready` and `subkey` are unchanged after it.
- R9: After reset, `ready` is low, `subkey` is 0 and the stored key is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Store `key_in` as the secret key |
| key_in | input | 128 | Secret key value |
| req | input | 1 | Subkey request, accepted when idle |
| round | input | 4 | Round or FL-layer number, from 1 |
| sel | input | 4 | Slot: 0-3 KO1-4, 4-6 KI1-3, 7 KL left, 8 KL right |
| ready | output | 1 | `subkey` holds the answer to the last request |
| subkey | output | 16 | Requested 16-bit subkey |

## Verification
A key load can fall in the same cycle as a request, and it can also land while a derived word is still being computed. The bench drives `key_load` and `req` together. It then checks that `ready` stays low for the following cycles and that the next request returns a word from the new key. In a second case it starts a KI request and loads a key on the very next edge. `ready` must not rise one cycle later, as it would if the abandoned FI result were delivered.

// File: rtl/subkey_gen.sv
module subkey_gen (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_load,
  input  logic [127:0] key_in,
  input  logic         req,
  input  logic [3:0]   round,
  input  logic [3:0]   sel,
  output logic         ready,
  output logic [15:0]  subkey
);
  localparam int NWORD = 8;
  localparam int WW = 16;
  localparam int KW = NWORD * WW;

  function automatic logic [6:0] mul7(input logic [6:0] a, input logic [6:0] b);
    logic [6:0] p, t;
    p = '0;
    t = a;
    for (int i = 0; i < 7; i++) begin
      if (b[i]) p = p ^ t;
      t = t[6] ? ({t[5:0], 1'b0} ^ 7'h03) : {t[5:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [8:0] mul9(input logic [8:0] a, input logic [8:0] b);
    logic [8:0] p, t;
    p = '0;
    t = a;
    for (int i = 0; i < 9; i++) begin
      if (b[i]) p = p ^ t;
      t = t[8] ? ({t[7:0], 1'b0} ^ 9'h011) : {t[7:0], 1'b0};
    end
    return p;
  endfunction

  function automatic logic [6:0] sbox7(input logic [6:0] v);
    return mul7(mul7(v, v), v);
  endfunction

  function automatic logic [8:0] sbox9(input logic [8:0] v);
    return mul9(mul9(v, v), v);
  endfunction

  function automatic logic [15:0] fi(input logic [15:0] x, input logic [15:0] k);
    logic [8:0] a;
    logic [6:0] b;
    a = x[15:7];
    b = x[6:0];
    a = sbox9(a) ^ {2'b00, b};
    b = sbox7(b) ^ a[6:0];
    b = b ^ k[15:9];
    a = a ^ k[8:0];
    a = sbox9(a) ^ {2'b00, b};
    b = sbox7(b) ^ a[6:0];
    return {b, a};
  endfunction

  logic [KW-1:0] key_q;
  logic          busy_q;
  logic [2:0]    widx_q;
  logic          ready_q;
  logic [WW-1:0] sk_q;

  logic [WW-1:0] kw [0:NWORD-1];
  for (genvar g = 0; g < NWORD; g++) begin : g_words
    assign kw[g] = key_q[KW-1-WW*g -: WW];
  end

  logic [3:0] rm1;
  logic [2:0] r0, h0;
  logic [2:0] idx;
  logic       ext, valid, accept;

  assign rm1 = round - 4'd1;
  assign r0  = rm1[2:0];
  assign h0  = rm1[3:1];

  always_comb begin
    idx   = r0;
    ext   = 1'b0;
    valid = 1'b1;
    case (sel)
      4'd0: idx = r0;
      4'd1: idx = r0 + 3'd2;
      4'd2: idx = r0 + 3'd7;
      4'd3: idx = r0 + 3'd4;
      4'd4: begin idx = r0 + 3'd5; ext = 1'b1; end
      4'd5: begin idx = r0 + 3'd1; ext = 1'b1; end
      4'd6: begin idx = r0 + 3'd3; ext = 1'b1; end
      4'd7: begin
        if (round[0]) idx = h0;
        else begin idx = h0 + 3'd2; ext = 1'b1; end
      end
      4'd8: begin
        if (round[0]) begin idx = h0 + 3'd6; ext = 1'b1; end
        else idx = h0 + 3'd4;
      end
      default: valid = 1'b0;
    endcase
  end

  assign accept = req && valid && !busy_q && !key_load;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q   <= '0;
      busy_q  <= 1'b0;
      widx_q  <= '0;
      ready_q <= 1'b0;
      sk_q    <= '0;
    end else if (key_load) begin
      key_q   <= key_in;
      busy_q  <= 1'b0;
      ready_q <= 1'b0;
    end else if (accept) begin
      if (ext) begin
        busy_q  <= 1'b1;
        widx_q  <= idx;
        ready_q <= 1'b0;
      end else begin
        sk_q    <= kw[idx];
        ready_q <= 1'b1;
      end
    end else if (busy_q) begin
      sk_q    <= fi(kw[widx_q], kw[widx_q + 3'd1]);
      busy_q  <= 1'b0;
      ready_q <= 1'b1;
    end
  end

  assign ready  = ready_q;
  assign subkey = sk_q;

  p_plain_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !ext) |=> ready);
  p_ext_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ext) |=> (!ready && busy_q));
  p_ext_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !key_load) |=> (ready && !busy_q));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !accept && !key_load) |=> (ready && $stable(subkey)));
  p_load_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> (!ready && !busy_q));
  p_bad_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !valid && !busy_q && !key_load) |=> ($stable(ready) && $stable(subkey)));
endmodule

// File: tb/subkey_gen_tb.sv
module subkey_gen_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0;
  logic [127:0] key_in = '0;
  logic         req = 1'b0;
  logic [3:0]   round = 4'd1;
  logic [3:0]   sel = 4'd0;
  logic         ready;
  logic [15:0]  subkey;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [127:0] KEYS [3] = '{
    128'h0011_2233_4455_6677_8899_aabb_ccdd_eeff,
    128'hfedc_ba98_7654_3210_0f1e_2d3c_4b5a_6978,
    128'h8000_0001_ffff_0000_1357_9bdf_2468_ace0
  };

  always #5 clk = ~clk;

  subkey_gen u_dut (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
    .req(req), .round(round), .sel(sel), .ready(ready), .subkey(subkey)
  );

  function automatic int gfmul(int a, int b, int n, int poly);
    int p = 0;
    for (int i = n - 1; i >= 0; i--) begin
      p = p << 1;
      if (((p >> n) & 1) != 0) p = p ^ ((1 << n) | poly);
      if (((b >> i) & 1) != 0) p = p ^ a;
    end
    return p;
  endfunction

  function automatic int cube(int v, int n, int poly);
    return gfmul(gfmul(v, v, n, poly), v, n, poly);
  endfunction

  function automatic logic [15:0] m_fi(logic [15:0] x, logic [15:0] k);
    int a, b;
    a = int'(x) >> 7;
    b = int'(x) & 'h7f;
    a = cube(a, 9, 'h11) ^ b;
    b = cube(b, 7, 'h03) ^ (a & 'h7f);
    b = b ^ (int'(k) >> 9);
    a = a ^ (int'(k) & 'h1ff);
    a = cube(a, 9, 'h11) ^ b;
    b = cube(b, 7, 'h03) ^ (a & 'h7f);
    return 16'((b << 9) | a);
  endfunction

  function automatic logic [15:0] kword(logic [127:0] key, int i);
    return key[128 - 16 * i +: 16];
  endfunction

  logic [15:0] ext_tab [1:8];

  task automatic build_ext(logic [127:0] key);
    for (int i = 1; i <= 8; i++) ext_tab[i] = m_fi(kword(key, i), kword(key, (i % 8) + 1));
  endtask

  function automatic int wrap(int x);
    return (x > 8) ? x - 8 : x;
  endfunction

  task automatic expect_word(logic [127:0] key, int r, int s, output logic [15:0] w, output bit is_ext);
    int j;
    is_ext = 1'b0;
    j = r;
    case (s)
      0: j = r;
      1: j = wrap(r + 2);
      2: j = wrap(r + 7);
      3: j = wrap(r + 4);
      4: begin j = wrap(r + 5); is_ext = 1'b1; end
      5: begin j = wrap(r + 1); is_ext = 1'b1; end
      6: begin j = wrap(r + 3); is_ext = 1'b1; end
      7: if (r % 2 == 1) j = (r + 1) / 2; else begin j = r / 2 + 2; is_ext = 1'b1; end
      default: if (r % 2 == 1) begin j = wrap((r + 1) / 2 + 6); is_ext = 1'b1; end
               else j = wrap(r / 2 + 4);
    endcase
    w = is_ext ? ext_tab[j] : kword(key, j);
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_key(logic [127:0] k);
    @(negedge clk);
    key_load = 1'b1;
    key_in = k;
    @(negedge clk);
    key_load = 1'b0;
    build_ext(k);
  endtask

  task automatic ask(logic [127:0] key, int r, int s, string tag);
    logic [15:0] w;
    bit is_ext;
    expect_word(key, r, s, w, is_ext);
    @(negedge clk);
    req = 1'b1;
    round = 4'(r);
    sel = 4'(s);
    @(negedge clk);
    req = 1'b0;
    if (is_ext) begin
      chk(ready == 1'b0, {tag, " derived word not ready in first cycle"}, 32'(ready), 32'd0);
      @(negedge clk);
    end
    chk(ready == 1'b1 && subkey == w, tag, {15'd0, ready, subkey}, {16'd1, w});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(ready == 1'b0, "R9 ready low after reset", 32'(ready), 32'd0);
    chk(subkey == 16'h0, "R9 subkey zero after reset", 32'(subkey), 32'd0);
    build_ext('0);
    ask('0, 3, 0, "R9 reset key is zero (KO1)");
    ask('0, 2, 4, "R9 R3 FI of zero key words");

    for (int kk = 0; kk < 3; kk++) begin
      load_key(KEYS[kk]);
      chk(ready == 1'b0, "R7 ready low after key load", 32'(ready), 32'd0);
      for (int r = 1; r <= 10; r++) begin
        for (int s = 0; s <= 8; s++) begin
          if (s < 7 && r > 8) continue;
          if (s < 4) ask(KEYS[kk], r, s, "R1 KO subkey");
          else if (s < 7) ask(KEYS[kk], r, s, "R2 R3 KI subkey");
          else ask(KEYS[kk], r, s, "R4 KL subkey");
        end
      end
    end

    ask(KEYS[2], 8, 2, "R5 wrap round 8 KO3 gives K7");
    chk(subkey == kword(KEYS[2], 7), "R5 KO3 equals K7", 32'(subkey), 32'(kword(KEYS[2], 7)));
    ask(KEYS[2], 10, 8, "R5 wrap KL right of layer 10 gives K1");

    held = subkey;
    repeat (4) @(negedge clk);
    chk(ready == 1'b1 && subkey == held, "R6 answer held while idle", {15'd0, ready, subkey}, {16'd1, held});

    @(negedge clk);
    req = 1'b1; round = 4'd2; sel = 4'd9;
    @(negedge clk);
    req = 1'b0;
    chk(ready == 1'b1 && subkey == held, "R8 selector 9 ignored", {15'd0, ready, subkey}, {16'd1, held});
    @(negedge clk);
    req = 1'b1; sel = 4'd15;
    @(negedge clk);
    req = 1'b0;
    chk(ready == 1'b1 && subkey == held, "R8 selector 15 ignored", {15'd0, ready, subkey}, {16'd1, held});

    @(negedge clk);
    key_load = 1'b1; key_in = KEYS[0];
    req = 1'b1; round = 4'd1; sel = 4'd0;
    @(negedge clk);
    key_load = 1'b0; req = 1'b0;
    build_ext(KEYS[0]);
    chk(ready == 1'b0, "R7 same-cycle request dropped", 32'(ready), 32'd0);
    @(negedge clk);
    chk(ready == 1'b0, "R7 dropped request never answers", 32'(ready), 32'd0);
    ask(KEYS[0], 1, 0, "R7 new key in use after load");

    @(negedge clk);
    req = 1'b1; round = 4'd3; sel = 4'd4;
    @(negedge clk);
    req = 1'b0;
    key_load = 1'b1; key_in = KEYS[1];
    @(negedge clk);
    key_load = 1'b0;
    build_ext(KEYS[1]);
    chk(ready == 1'b0, "R7 load during derivation clears ready", 32'(ready), 32'd0);
    @(negedge clk);
    chk(ready == 1'b0, "R7 abandoned derivation not delivered", 32'(ready), 32'd0);
    ask(KEYS[1], 3, 4, "R7 R2 derived word from new key");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule